// File: doc/BRIEF.md
# Vector State Write Legalizer

This block holds a packed vector-state word and turns every software write to it into a legal stored value. The word carries a maximum vector length, a current vector length, a sub-vector group size, source and destination element offsets, and source and destination sub-vector offsets. Both lengths and the group size are kept minus one, so a zero field means a length of one.

A write names one of four kinds: a whole-word write, a 5-bit immediate write of the current length, a 5-bit immediate write of the maximum length, or a group-size write that carries a plain count. The block clamps the fields in dependency order. The maximum length is clamped against XLEN. The current length is clamped against the clamped maximum. The element offsets are clamped against the clamped current length, and the sub-vector offsets against the group size. A group-size count outside 1 to 4 is refused: the block raises an exception pulse and keeps the stored word as it was.

The core is combinational. The register loads its result on the write strobe. CSR address decode and trap handling sit outside the block. XLEN must be at least 32.

Top module: `vstate_legalizer`

## Requirements
- R1: The stored word has field width LW = clog2(XLEN), with bit 0 as the least significant bit. The fields are: maximum length minus one at [LW-1:0], current length minus one at [2LW-1:LW], source offset at [3LW-1:2LW], destination offset at [4LW-1:3LW], group size minus one at [4LW+1:4LW], source sub-offset at [4LW+3:4LW+2], and destination sub-offset at [4LW+5:4LW+4]. Reset clears the whole word, which gives lengths of 1 and offsets of 0, and holds exc_o low.
- R2: A whole-word write (kind 0) stores the maximum-length field clamped to at most XLEN-1, so the maximum length never exceeds XLEN.
- R3: The stored current-length field never exceeds the stored maximum-length field. A larger request is reduced to the maximum.
- R4: On a whole-word write, each element offset is clamped to at most the stored current-length field, that is, to VL-1.
- R5: On a whole-word write, each sub-vector offset is clamped to at most the stored group-size field, that is, to the group size minus one.
- R6: A group-size write (kind 3) whose data equals 1 to 4 stores data-1 in the group field, re-clamps both sub-vector offsets against it, and leaves all other fields unchanged.
- R7: A group-size write whose data is 0 or greater than 4 leaves the stored word unchanged and makes exc_o high for exactly the cycle after the write.
- R8: A length immediate write (kind 1) takes data[4:0] as length minus one (0 to 31 meaning 1 to 32), clamps it to the stored maximum, clears both element offsets, and keeps the remaining fields.
- R9: A maximum immediate write (kind 2) takes data[4:0] as maximum minus one and clamps it to XLEN-1. It then re-clamps the current length and both element offsets against the new limits and keeps the group fields.
- R10: state_o changes only on a clock edge at which wr_en_i is high. Cycles with wr_en_i low leave it unchanged, whatever the values on wr_kind_i and wr_data_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_kind_i | input | 2 | Write kind: 0 word, 1 length imm, 2 max imm, 3 group count |
| wr_data_i | input | 4*LW+6 | Write data |
| state_o | output | 4*LW+6 | Stored legal state word |
| exc_o | output | 1 | Illegal group-size pulse, one cycle after the write |

## Verification
The bench builds the block with XLEN=48. At that width the 6-bit maximum-length field can encode 64, which is more than 48, so the clamp against XLEN-1 really cuts values instead of never acting, as it would at a power-of-two XLEN. The same choice lets length immediates of 31 land both below and above a reduced maximum, which exercises the chain from maximum to length to offsets in both directions. Group counts of 0, 5 and a value with a high data bit set reach the refusal path, while each of 1 to 4 reaches the legal path.

// File: rtl/vstate_pkg.sv
package vstate_pkg;

  typedef enum logic [1:0] {
    VS_WR_WORD    = 2'd0,
    VS_WR_LEN_IMM = 2'd1,
    VS_WR_MAX_IMM = 2'd2,
    VS_WR_GROUP   = 2'd3
  } vs_wr_kind_e;

  localparam int unsigned VS_GRP_W = 2;
  localparam int unsigned VS_IMM_W = 5;
  localparam int unsigned VS_GRP_MAX = 4;

  function automatic int unsigned vs_word_w(input int unsigned lw);
    return 4 * lw + 3 * VS_GRP_W;
  endfunction

endpackage

// File: rtl/vs_clamp.sv
module vs_clamp #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] res_o
);
  always_comb res_o = (val_i > lim_i) ? lim_i : val_i;
endmodule

// File: rtl/vs_state_reg.sv
module vs_state_reg #(
  parameter int unsigned W = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/vs_legalize.sv
module vs_legalize
  import vstate_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned LW = $clog2(XLEN),
  localparam int unsigned GW = VS_GRP_W,
  localparam int unsigned WW = vs_word_w(LW)
) (
  input  logic [1:0]    kind_i,
  input  logic [WW-1:0] data_i,
  input  logic [WW-1:0] cur_i,
  output logic [WW-1:0] nxt_o,
  output logic          exc_o
);
  localparam int unsigned OFS_SRC = 2 * LW;
  localparam int unsigned OFS_GRP = 4 * LW;
  localparam logic [LW-1:0] MAX_LIM = LW'(XLEN - 1);

  vs_wr_kind_e kind;
  logic [LW-1:0] imm;
  logic          word_w, len_w, max_w, grp_w;

  always_comb begin
    kind   = vs_wr_kind_e'(kind_i);
    imm    = LW'(data_i[VS_IMM_W-1:0]);
    word_w = (kind == VS_WR_WORD);
    len_w  = (kind == VS_WR_LEN_IMM);
    max_w  = (kind == VS_WR_MAX_IMM);
    grp_w  = (kind == VS_WR_GROUP);
  end

  // group count must be 1..4 over the whole data word
  logic grp_bad;
  always_comb begin
    grp_bad = (data_i == '0) || (data_i > WW'(VS_GRP_MAX));
    exc_o   = grp_w && grp_bad;
  end

  // stage 1: maximum length against XLEN
  logic [LW-1:0] max_raw, max_n;
  always_comb begin
    if (word_w)     max_raw = data_i[LW-1:0];
    else if (max_w) max_raw = imm;
    else            max_raw = cur_i[LW-1:0];
  end
  vs_clamp #(.W(LW)) u_max_clamp (.val_i(max_raw), .lim_i(MAX_LIM), .res_o(max_n));

  // stage 2: length against clamped maximum
  logic [LW-1:0] len_raw, len_n;
  always_comb begin
    if (word_w)     len_raw = data_i[2*LW-1:LW];
    else if (len_w) len_raw = imm;
    else            len_raw = cur_i[2*LW-1:LW];
  end
  vs_clamp #(.W(LW)) u_len_clamp (.val_i(len_raw), .lim_i(max_n), .res_o(len_n));

  // stage 3: element offsets against clamped length
  logic [LW-1:0] ofs_n [2];
  for (genvar g = 0; g < 2; g++) begin : g_elem_ofs
    localparam int unsigned LO = OFS_SRC + g * LW;
    logic [LW-1:0] raw;
    always_comb begin
      if (word_w)     raw = data_i[LO+LW-1:LO];
      else if (len_w) raw = '0;
      else            raw = cur_i[LO+LW-1:LO];
    end
    vs_clamp #(.W(LW)) u_ofs_clamp (.val_i(raw), .lim_i(len_n), .res_o(ofs_n[g]));
  end

  // group size: count-1 wraps 4 to 3 in two bits
  logic [GW-1:0] grp_n;
  always_comb begin
    if (word_w)                 grp_n = data_i[OFS_GRP+GW-1:OFS_GRP];
    else if (grp_w && !grp_bad) grp_n = GW'(data_i[GW-1:0] - GW'(1));
    else                        grp_n = cur_i[OFS_GRP+GW-1:OFS_GRP];
  end

  // stage 4: sub-vector offsets against group size
  logic [GW-1:0] sub_n [2];
  for (genvar g = 0; g < 2; g++) begin : g_sub_ofs
    localparam int unsigned LO = OFS_GRP + (g + 1) * GW;
    logic [GW-1:0] raw;
    always_comb begin
      if (word_w) raw = data_i[LO+GW-1:LO];
      else        raw = cur_i[LO+GW-1:LO];
    end
    vs_clamp #(.W(GW)) u_sub_clamp (.val_i(raw), .lim_i(grp_n), .res_o(sub_n[g]));
  end

  always_comb nxt_o = {sub_n[1], sub_n[0], grp_n, ofs_n[1], ofs_n[0], len_n, max_n};

endmodule

// File: rtl/vstate_legalizer.sv
module vstate_legalizer
  import vstate_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned LW = $clog2(XLEN),
  localparam int unsigned WW = vs_word_w(LW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_kind_i,
  input  logic [WW-1:0] wr_data_i,
  output logic [WW-1:0] state_o,
  output logic          exc_o
);
  logic [WW-1:0] nxt;
  logic          exc_c;

  vs_legalize #(.XLEN(XLEN)) u_legal (
    .kind_i(wr_kind_i),
    .data_i(wr_data_i),
    .cur_i (state_o),
    .nxt_o (nxt),
    .exc_o (exc_c)
  );

  vs_state_reg #(.W(WW)) u_state (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (wr_en_i && !exc_c),
    .d_i   (nxt),
    .q_o   (state_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exc_o <= 1'b0;
    else         exc_o <= wr_en_i && exc_c;
  end

endmodule

// File: rtl/vstate_legalizer_chk.sv
module vstate_legalizer_chk #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned LW = $clog2(XLEN),
  localparam int unsigned WW = 4 * LW + 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [1:0]    wr_kind_i,
  input logic [WW-1:0] wr_data_i,
  input logic [WW-1:0] state_o,
  input logic          exc_o
);
  logic [LW-1:0] f_max, f_len, f_src, f_dst;
  logic [1:0]    f_grp, f_ssub, f_dsub;
  always_comb begin
    f_max  = state_o[LW-1:0];
    f_len  = state_o[2*LW-1:LW];
    f_src  = state_o[3*LW-1:2*LW];
    f_dst  = state_o[4*LW-1:3*LW];
    f_grp  = state_o[4*LW+1:4*LW];
    f_ssub = state_o[4*LW+3:4*LW+2];
    f_dsub = state_o[4*LW+5:4*LW+4];
  end

  p_max_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(f_max) <= XLEN - 1);
  p_len_le_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_len <= f_max);
  p_ofs_le_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_src <= f_len) && (f_dst <= f_len));
  p_sub_le_grp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_ssub <= f_grp) && (f_dsub <= f_grp));
  p_bad_grp_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == 2'd3 && (wr_data_i == '0 || wr_data_i > WW'(4))) |=> exc_o);
  p_exc_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> $stable(state_o));
  p_len_imm_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == 2'd1) |=> (f_src == '0 && f_dst == '0));
  p_idle_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(state_o));
endmodule

bind vstate_legalizer vstate_legalizer_chk #(.XLEN(XLEN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_kind_i(wr_kind_i),
  .wr_data_i(wr_data_i),
  .state_o  (state_o),
  .exc_o    (exc_o)
);

// File: tb/vstate_legalizer_tb.sv
`timescale 1ns/1ps
module vstate_legalizer_tb;
  localparam int XL = 48;
  localparam int LW = 6;
  localparam int WW = 4 * LW + 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_kind = '0;
  logic [WW-1:0] wr_data = '0;
  logic [WW-1:0] state;
  logic          exc;

  always #4 clk = ~clk;

  vstate_legalizer #(.XLEN(XL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_kind_i(wr_kind),
    .wr_data_i(wr_data), .state_o(state), .exc_o(exc)
  );

  typedef struct {
    logic [WW-1:0] word;
    logic          exc;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int m[7];  // max, len, src, dst, grp, ssub, dsub (stored values)
  logic due = 1'b0;

  function automatic int mn(int a, int b);
    return (a > b) ? b : a;
  endfunction

  function automatic logic [WW-1:0] pack(int f[7]);
    return {2'(f[6]), 2'(f[5]), 2'(f[4]), 6'(f[3]), 6'(f[2]), 6'(f[1]), 6'(f[0])};
  endfunction

  function automatic logic [WW-1:0] mk(int mx, int ln, int s, int d, int g, int ss, int ds);
    int f[7];
    f = '{mx, ln, s, d, g, ss, ds};
    return pack(f);
  endfunction

  task automatic check(bit ok, string tag, logic [WW-1:0] act, logic [WW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wr(int kind, logic [WW-1:0] d, string tag);
    exp_t e;
    int imm;
    imm = int'(d[4:0]);
    e.exc = 1'b0;
    case (kind)
      0: begin
        m[0] = mn(int'(d[5:0]), XL - 1);
        m[1] = mn(int'(d[11:6]), m[0]);
        m[2] = mn(int'(d[17:12]), m[1]);
        m[3] = mn(int'(d[23:18]), m[1]);
        m[4] = int'(d[25:24]);
        m[5] = mn(int'(d[27:26]), m[4]);
        m[6] = mn(int'(d[29:28]), m[4]);
      end
      1: begin
        m[1] = mn(imm, m[0]);
        m[2] = 0;
        m[3] = 0;
      end
      2: begin
        m[0] = mn(imm, XL - 1);
        m[1] = mn(m[1], m[0]);
        m[2] = mn(m[2], m[1]);
        m[3] = mn(m[3], m[1]);
      end
      default: begin
        if (d == '0 || d > WW'(4)) e.exc = 1'b1;
        else begin
          m[4] = int'(d) - 1;
          m[5] = mn(m[5], m[4]);
          m[6] = mn(m[6], m[4]);
        end
      end
    endcase
    e.word = pack(m);
    e.tag = tag;
    @(negedge clk);
    wr_en = 1'b1;
    wr_kind = 2'(kind);
    wr_data = d;
    q.push_back(e);
  endtask

  always @(posedge clk) due <= rst_n && wr_en;

  always @(negedge clk) begin
    if (due && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(state === e.word, {e.tag, " state"}, state, e.word);
      check(exc === e.exc, {e.tag, " exc"}, WW'(exc), WW'(e.exc));
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    check(state === '0, "R1 reset word", state, '0);
    check(exc === 1'b0, "R1 reset exc", WW'(exc), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(state === '0, "R1 after release", state, '0);

    wr(0, mk(63, 63, 63, 10, 2, 3, 1), "R2 R3 R4 R5 oversize word");
    wr(0, mk(9, 20, 5, 30, 0, 3, 0), "R3 R4 R5 len above max");
    wr(0, mk(47, 40, 40, 39, 3, 3, 2), "R2 max at limit");
    wr(1, WW'(3), "R8 len imm small");
    wr(0, mk(9, 9, 7, 8, 3, 2, 1), "R4 offsets set");
    wr(1, {{(WW-5){1'b1}}, 5'd31}, "R8 len imm clamped upper bits ignored");
    wr(2, WW'(31), "R9 max imm grow");
    wr(1, WW'(31), "R8 len imm full 32");
    wr(0, mk(31, 20, 18, 19, 3, 3, 3), "R4 offsets high");
    wr(2, WW'(2), "R9 max imm shrink reclamp");
    wr(3, WW'(3), "R6 group 3");
    wr(3, WW'(1), "R6 group 1 clamps subs");
    wr(3, WW'(4), "R6 group 4");
    wr(0, mk(5, 5, 1, 2, 3, 3, 2), "R5 subs within group");
    wr(3, WW'(0), "R7 group 0 refused");
    wr(3, WW'(5), "R7 group 5 refused");
    wr(3, WW'(2) | (WW'(1) << 20), "R7 group high bit refused");
    wr(3, WW'(2), "R6 group 2 after refusal");

    @(negedge clk);
    wr_en = 1'b0;
    wr_kind = 2'd0;
    wr_data = '1;
    repeat (4) @(negedge clk);
    check(state === pack(m), "R10 idle ignores bus", state, pack(m));
    check(exc === 1'b0, "R7 pulse is single cycle", WW'(exc), '0);
    wr_kind = 2'd3;
    wr_data = '0;
    repeat (2) @(negedge clk);
    check(exc === 1'b0, "R10 idle bad group no exc", WW'(exc), '0);
    check(state === pack(m), "R10 idle bad group no change", state, pack(m));
    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard left %0d items", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule